// File: doc/BRIEF.md
# Phase-Scheduled Virtual Wire Link

This block sits in one partition of a design that has been split across several programmable devices. It carries a group of logical signals to a neighbouring partition, and brings a group back, over a single physical wire in each direction. It does not multiplex freely. Each emulation clock cycle is cut into a fixed number of phases. Every phase opens with an evaluation interval, in which the partition's combinational logic settles. A communication interval follows, in which one slice of the outgoing signals is shifted onto the wire while the matching slice from the far side is shifted in.

The schedule is static. Phase p always carries outgoing bits `tx_vec[p*K +: K]`, and it always delivers incoming bits to `rx_vec[p*K +: K]`. The partition's logic presents its outputs for phase p before that phase's evaluation interval ends. It may use the inputs received in phase p from the following phase onward. `emu_tick` marks the last fast-clock cycle of the last phase. That is the edge at which the user's state registers advance.

Top module: `vw_link`

## Requirements
- R1: While `rst_n` is low at a clock edge, the link returns to phase 0, sub-cycle 0, with `rx_vec` all zero. After such an edge, `phase_idx`, `comm_en`, `wire_out` and `emu_tick` read 0.
- R2: Each phase lasts EVAL_CYC+K fast-clock cycles. `phase_idx` then advances by one, and it returns to 0 after phase NPH-1.
- R3: `comm_en` is high in exactly the last K cycles of every phase and low in the first EVAL_CYC cycles.
- R4: `wire_out` is 0 whenever `comm_en` is low.
- R5: The slice `tx_vec[p*K +: K]` is captured at the clock edge that ends the last evaluation cycle of phase p. Values on `tx_vec` at any other time have no effect on `wire_out`.
- R6: During the j-th communication cycle of a phase (j counted from 0), `wire_out` equals bit j of the captured slice, least significant bit first.
- R7: `wire_in` is sampled at the end of each communication cycle. The bit taken in the j-th communication cycle of phase p lands in `rx_vec[p*K + j]`, written at the edge that ends phase p.
- R8: `rx_vec` changes only at the edge ending a phase, and then only in that phase's slice. Each slice holds until the same phase of the next emulation cycle.
- R9: `emu_tick` is high exactly in the final cycle of phase NPH-1 and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (communication) clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_vec | input | NPH*K | Logical outputs of this partition, slice p sent in phase p |
| wire_in | input | 1 | Shared wire from the neighbouring partition |
| wire_out | output | 1 | Shared wire to the neighbouring partition |
| rx_vec | output | NPH*K | Logical inputs received, slice p written at end of phase p |
| phase_idx | output | max(1, clog2(NPH)) | Current phase number |
| comm_en | output | 1 | High during communication intervals |
| emu_tick | output | 1 | High in the last cycle of the emulation clock cycle |

## Verification
The bench builds the link with NPH=3, K=5 and EVAL_CYC=1. Three phases make the phase counter wrap short of a power of two. An odd slice width gives a phase length of six cycles. A single evaluation cycle puts the load edge right after the phase boundary. The wire runs in two modes: looped straight back into `wire_in`, so the received slices must match what was sent, and driven by the bench with independent random bits. `tx_vec` is re-randomised on every cycle, so any capture outside the load edge shows up on the wire. A reset in the middle of a run checks that the schedule restarts cleanly.

// File: rtl/vw_pkg.sv
// Package: shared types and helpers for the virtual wire link.
// Assumes: nothing beyond the 1800-2017 language.
package vw_pkg;

    // Which sub-interval of a phase the link is in.
    typedef enum logic {
        IV_EVAL = 1'b0,
        IV_COMM = 1'b1
    } interval_e;

    // Width of an index that must count to n-1, never below one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vw_sched.sv
// Module: vw_sched
// Produces the static phase schedule. It counts fast-clock cycles inside
// a phase, steps the phase number, and decodes the load, communicate,
// end-of-phase and emulation-tick strobes from those two counters.
// Assumes: EVAL_CYC >= 1 and K >= 1, so a phase is at least two cycles.
module vw_sched
    import vw_pkg::*;
#(
    parameter int unsigned NPH      = 4,
    parameter int unsigned K        = 4,
    parameter int unsigned EVAL_CYC = 2,
    parameter int unsigned PW       = 2,
    parameter int unsigned SW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase_o,
    output interval_e     ival_o,
    output logic          load_o,
    output logic          last_o,
    output logic          tick_o
);

    localparam int unsigned PLEN = EVAL_CYC + K;

    logic [SW-1:0] sub_q;
    logic [PW-1:0] phase_q;

    // Purpose: advance the sub-cycle counter and wrap the phase number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q   <= '0;
            phase_q <= '0;
        end else if (sub_q == SW'(PLEN - 1)) begin
            sub_q   <= '0;
            phase_q <= (phase_q == PW'(NPH - 1)) ? '0 : phase_q + 1'b1;
        end else begin
            sub_q   <= sub_q + 1'b1;
        end
    end

    // Purpose: decode interval and strobes from the counters.
    always_comb begin
        ival_o  = (sub_q >= SW'(EVAL_CYC)) ? IV_COMM : IV_EVAL;
        load_o  = (sub_q == SW'(EVAL_CYC - 1));
        last_o  = (sub_q == SW'(PLEN - 1));
        tick_o  = last_o && (phase_q == PW'(NPH - 1));
        phase_o = phase_q;
    end

endmodule

// File: rtl/vw_tx_loop.sv
// Module: vw_tx_loop
// Outgoing shift loop. It loads the slice of the current phase in parallel
// on the load strobe, then shifts it out least significant bit first
// while communication is enabled. The wire is held low outside
// communication.
// Assumes: K >= 2; the load strobe never coincides with communication.
module vw_tx_loop
#(
    parameter int unsigned NPH = 4,
    parameter int unsigned K   = 4,
    parameter int unsigned PW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPH*K-1:0] tx_vec,
    input  logic [PW-1:0]    phase,
    input  logic             load,
    input  logic             comm,
    output logic             wire_o
);

    logic [K-1:0] slice;
    logic [K-1:0] sreg_q;

    // Purpose: select the slice scheduled for the current phase.
    always_comb begin
        slice = '0;
        for (int p = 0; p < int'(NPH); p++) begin
            if (phase == PW'(p)) slice = tx_vec[p*K +: K];
        end
    end

    // Purpose: parallel load, then shift toward bit 0 during communication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= slice;
        end else if (comm) begin
            sreg_q <= {1'b0, sreg_q[K-1:1]};
        end
    end

    // Purpose: drive the wire only inside communication intervals.
    always_comb wire_o = comm & sreg_q[0];

endmodule

// File: rtl/vw_rx_loop.sv
// Module: vw_rx_loop
// Incoming shift loop. It shifts the wire in at the top while communication
// is enabled. At the end of a phase it copies the completed word into
// that phase's slice of the received vector, which then holds until
// the same phase comes round again.
// Assumes: K >= 2; last is high only in a communication cycle.
module vw_rx_loop
#(
    parameter int unsigned NPH = 4,
    parameter int unsigned K   = 4,
    parameter int unsigned PW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wire_i,
    input  logic [PW-1:0]    phase,
    input  logic             comm,
    input  logic             last,
    output logic [NPH*K-1:0] rx_vec
);

    logic [K-1:0] rsh_q;
    logic [K-1:0] rsh_nxt;

    // Purpose: next shift word, with the newest bit entering at the top.
    always_comb rsh_nxt = {wire_i, rsh_q[K-1:1]};

    // Purpose: accumulate bits during communication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsh_q <= '0;
        end else if (comm) begin
            rsh_q <= rsh_nxt;
        end
    end

    for (genvar p = 0; p < NPH; p++) begin : g_slot
        logic [K-1:0] hold_q;

        // Purpose: latch the completed word at the end of phase p.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q <= '0;
            end else if (last && (phase == PW'(p))) begin
                hold_q <= rsh_nxt;
            end
        end

        assign rx_vec[p*K +: K] = hold_q;
    end

endmodule

// File: rtl/vw_link.sv
// Module: vw_link (top)
// One partition's end of a phase-scheduled virtual wire. It ties together
// the schedule, the outgoing loop and the incoming loop.
// Assumes: NPH >= 1, K >= 2, EVAL_CYC >= 1; the far partition runs the
// same schedule in lock-step from the same reset.
module vw_link
    import vw_pkg::*;
#(
    parameter int unsigned NPH      = 4,
    parameter int unsigned K        = 4,
    parameter int unsigned EVAL_CYC = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NPH*K-1:0]               tx_vec,
    input  logic                           wire_in,
    output logic                           wire_out,
    output logic [NPH*K-1:0]               rx_vec,
    output logic [idx_bits(NPH)-1:0]       phase_idx,
    output logic                           comm_en,
    output logic                           emu_tick
);

    localparam int unsigned PW = idx_bits(NPH);
    localparam int unsigned SW = idx_bits(EVAL_CYC + K);

    interval_e     ival;
    logic          load;
    logic          last;
    logic [PW-1:0] phase;

    vw_sched #(.NPH(NPH), .K(K), .EVAL_CYC(EVAL_CYC), .PW(PW), .SW(SW)) u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_o(phase),
        .ival_o (ival),
        .load_o (load),
        .last_o (last),
        .tick_o (emu_tick)
    );

    // Purpose: the enable gates both shifting and capture.
    always_comb comm_en = (ival == IV_COMM);

    vw_tx_loop #(.NPH(NPH), .K(K), .PW(PW)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tx_vec(tx_vec),
        .phase (phase),
        .load  (load),
        .comm  (comm_en),
        .wire_o(wire_out)
    );

    vw_rx_loop #(.NPH(NPH), .K(K), .PW(PW)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .wire_i(wire_in),
        .phase (phase),
        .comm  (comm_en),
        .last  (last),
        .rx_vec(rx_vec)
    );

    assign phase_idx = phase;

endmodule

// File: rtl/vw_chk.sv
// Module: vw_chk
// Temporal checks on the link's ports, bound into every vw_link instance.
// Assumes: rst_n is low at the first clock edge.
module vw_chk #(
    parameter int unsigned NPH = 4,
    parameter int unsigned PW  = 2,
    parameter int unsigned NB  = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] phase,
    input logic          comm_en,
    input logic          emu_tick,
    input logic          wire_out,
    input logic [NB-1:0] rx_vec
);

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |->
            (($past(phase) == PW'(NPH - 1)) ? (phase == '0) : (phase == $past(phase) + 1'b1)));

    // R3
    comm_ends_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(comm_en) |-> (phase != $past(phase)) || (NPH == 1));

    // R3
    comm_inside_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(comm_en) |-> $stable(phase));

    // R4
    quiet_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !comm_en |-> !wire_out);

    // R8
    rx_write_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vec != $past(rx_vec)) |-> $past(comm_en));

    // R9
    tick_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emu_tick |-> comm_en && (phase == PW'(NPH - 1)));

endmodule

bind vw_link vw_chk #(.NPH(NPH), .PW(PW), .NB(NPH*K)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase_idx),
    .comm_en (comm_en),
    .emu_tick(emu_tick),
    .wire_out(wire_out),
    .rx_vec  (rx_vec)
);

// File: tb/sim_vw_link.sv
// Bench for vw_link: random and directed stimulus against a schedule model.
module sim_vw_link;

    localparam int NPH  = 3;
    localparam int K    = 5;
    localparam int EV   = 1;
    localparam int PLEN = EV + K;
    localparam int NB   = NPH * K;
    localparam int PW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] tx_vec = '0;
    logic          drv_bit = 1'b0;
    logic          lb = 1'b0;
    logic          wire_in;
    logic          wire_out;
    logic [NB-1:0] rx_vec;
    logic [PW-1:0] phase_idx;
    logic          comm_en;
    logic          emu_tick;

    int errors = 0;
    int checks = 0;
    int t = 0;
    int mode = 0;
    logic [K-1:0]  ld;
    logic [K-1:0]  pend;
    logic [NB-1:0] exp_rx;

    always #10 clk = ~clk;

    assign wire_in = lb ? wire_out : drv_bit;

    vw_link #(.NPH(NPH), .K(K), .EVAL_CYC(EV)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_vec(tx_vec), .wire_in(wire_in),
        .wire_out(wire_out), .rx_vec(rx_vec), .phase_idx(phase_idx),
        .comm_en(comm_en), .emu_tick(emu_tick)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] gen_tx(input int m);
        case (m)
            1:       return '1;
            2:       return {NB{2'b01}};
            default: return NB'({$urandom, $urandom});
        endcase
    endfunction

    // One cycle: check the outputs of cycle t, then drive the inputs of cycle t.
    task automatic cycle();
        int  s = t % PLEN;
        int  p = (t / PLEN) % NPH;
        bit  ce = (s >= EV);
        logic expw = ce ? ld[s-EV] : 1'b0;
        logic b;
        chk(phase_idx == PW'(p), "R2 phase", 64'(phase_idx), 64'(p));
        chk(comm_en == ce, "R3 comm_en", 64'(comm_en), 64'(ce));
        chk(emu_tick == ((p == NPH-1) && (s == PLEN-1)), "R9 emu_tick", 64'(emu_tick),
            64'((p == NPH-1) && (s == PLEN-1)));
        chk(wire_out == expw, ce ? "R6 R5 wire bit" : "R4 quiet wire", 64'(wire_out), 64'(expw));
        chk(rx_vec == exp_rx, "R7 R8 rx_vec", 64'(rx_vec), 64'(exp_rx));
        tx_vec  = gen_tx(mode);
        drv_bit = (mode == 3) ? 1'b1 : 1'($urandom);
        #1;
        b = lb ? wire_out : drv_bit;
        if (s == EV-1) ld = tx_vec[p*K +: K];
        if (ce) pend[s-EV] = b;
        if (s == PLEN-1) exp_rx[p*K +: K] = pend;
        t++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs after reset edges
        chk(phase_idx == '0, "R1 phase", 64'(phase_idx), 0);
        chk(comm_en == 1'b0, "R1 comm_en", 64'(comm_en), 0);
        chk(wire_out == 1'b0, "R1 wire_out", 64'(wire_out), 0);
        chk(emu_tick == 1'b0, "R1 emu_tick", 64'(emu_tick), 0);
        chk(rx_vec == '0, "R1 rx_vec", 64'(rx_vec), 0);
        rst_n = 1'b1;
        t = 0; ld = '0; pend = '0; exp_rx = '0;
    endtask

    task automatic run(input int n, input int m, input bit loop);
        mode = m; lb = loop;
        for (int i = 0; i < n; i++) begin
            cycle();
            @(negedge clk);
        end
    endtask

    bit done = 1'b0;

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        run(300, 0, 1'b0);   // external random bits on the wire
        run(300, 0, 1'b1);   // loopback: received equals sent
        run(40, 1, 1'b1);    // all ones
        run(40, 2, 1'b0);    // alternating pattern, random receive
        run(5, 0, 1'b1);     // stop mid-phase, then reset
        do_reset();
        run(60, 3, 1'b0);    // constant ones received
        run(120, 0, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule